// File: doc/BRIEF.md
# Adaptive-Slope Percentage Differential Element

This block decides whether a protected bus has an internal fault. On every sample tick it accepts one signed current sample from each of `N_CH` feeder channels. Each sample is scaled by its channel's tap factor, and its sign can be flipped by a polarity setting. From the scaled currents the block forms two quantities. The operate quantity is the magnitude of their signed sum. The restraint quantity is the sum of their magnitudes.

The element picks up when the operate quantity is above a minimum level and also above a slope fraction of the restraint quantity. A classifier looks at a short onset window at the start of each half cycle. If restraint climbs there while operate does not follow, the disturbance is treated as external, and a steeper second slope is used until the disturbance has died away. If both quantities climb together, the disturbance is treated as internal and the first slope stays in force. A trip needs a settable run of consecutive pickup samples, with an optional extra delay added for gapped arresters. Once set, the trip stays latched until it is cleared.

All settings are static input ports. The classifier has four states:
- NORMAL: slope 1 is used.
- INTERNAL: slope 1 is used, and external patterns are ignored.
- EXTERNAL: slope 2 is used.
- HOLD: slope 2 is used while a counted ride-out runs.

Transitions:
- NORMAL goes to EXTERNAL on an external onset, or to INTERNAL on an internal onset.
- INTERNAL goes to NORMAL when restraint falls below the reset level.
- EXTERNAL goes to HOLD when restraint falls below the reset level.
- HOLD goes back to EXTERNAL when restraint climbs back to the reset level or above.
- HOLD goes to NORMAL when the ride-out count expires.

The trip state machine has three states:
- IDLE goes to TIMING on a pickup sample.
- TIMING goes back to IDLE on a sample without pickup.
- IDLE or TIMING goes to TRIPPED when the required pickup run is complete.
- TRIPPED goes to IDLE only on the clear input.

Top module: `busdiff_slope_elem`

## Requirements
- R1: Each channel's scaled current equals (sample × tap) arithmetically shifted right by `TAP_FRAC` (default 4, so tap 16 means unity), rounding toward minus infinity; channel k uses bits [k*SMP_W +: SMP_W] of `smp_i` and bits [k*TAP_W +: TAP_W] of `tap_i`.
- R2: When bit k of `pol_i` is 1, the scaled current of channel k is negated before both sums are formed.
- R3: Operate equals |Σ scaled|, and restraint equals Σ |scaled|; operate never exceeds restraint.
- R4: A sample picks up when operate > `min_op_i` and operate×256 > slope×restraint. The slope is `slope1_i` unless the classifier selects `slope2_i`; both slopes are in units of 1/256.
- R5: An onset sample classifies as external when all of the following hold: it lies inside the window, restraint rose by more than `rise_min_i` since the previous sample, and (operate rise)×256 < `prop_i`×(restraint rise). From NORMAL this enters EXTERNAL, and slope 2 already applies to that same sample. `secure_o` is 1 in EXTERNAL and HOLD.
- R6: An onset sample inside the window whose restraint rose by more than `rise_min_i` but which fails the external test classifies as internal. This enters INTERNAL (`internal_o` = 1) with slope 1. While in INTERNAL, later external patterns do not raise `secure_o`. INTERNAL returns to NORMAL on a sample with restraint < `rst_lvl_i`.
- R7: The onset window opens on a sample whose restraint is nonzero and where the sign of the largest-magnitude scaled channel differs from the last sign recorded on a nonzero-restraint sample. The lowest index wins ties, and the recorded sign is positive after reset. The window spans `win_len_i` samples, counting the opening one, and `win_len_i` = 0 disables classification.
- R8: In EXTERNAL, the first sample with restraint < `rst_lvl_i` enters HOLD. From there, slope 1 returns on the `hold_len_i`-th subsequent low sample; a `hold_len_i` of 0 behaves as 1. A sample at or above the reset level during HOLD returns to EXTERNAL, and the ride-out count restarts on the next drop.
- R9: `trip_o` sets on the sample that completes D+1 consecutive pickup samples. D is `dly_i`, plus `gap_extra_i` when `gap_en_i` = 1. A sample without pickup restarts the count.
- R10: `trip_o` stays 1 until `trip_rst_i` is high for a clock, which clears it and the pickup count. Results appear on the outputs in the cycle after the tick, and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick | input | 1 | One-cycle strobe marking a new set of samples |
| smp_i | input | N_CH*SMP_W | Signed samples, channel 0 in the low bits |
| tap_i | input | N_CH*TAP_W | Unsigned tap factors in units of 1/2^TAP_FRAC |
| pol_i | input | N_CH | Per-channel sign inversion |
| slope1_i | input | SLP_W | Normal slope in 1/256 |
| slope2_i | input | SLP_W | Secure slope in 1/256 |
| min_op_i | input | LVL_W | Minimum operate level |
| prop_i | input | SLP_W | Required operate/restraint rise ratio in 1/256 |
| rise_min_i | input | LVL_W | Restraint rise needed to classify |
| win_len_i | input | CNT_W | Onset window length in samples |
| rst_lvl_i | input | LVL_W | Restraint level marking the disturbance over |
| hold_len_i | input | CNT_W | Low-restraint samples before slope 1 returns |
| dly_i | input | CNT_W | Base trip delay in samples |
| gap_en_i | input | 1 | Adds the extra arrester delay |
| gap_extra_i | input | CNT_W | Extra delay in samples |
| trip_rst_i | input | 1 | Clears the latched trip |
| trip_o | output | 1 | Latched trip |
| secure_o | output | 1 | Slope 2 in force |
| internal_o | output | 1 | Internal disturbance declared |

## Verification
A wrong classifier state shows on `secure_o` or `internal_o` in the cycle after the offending tick. It can also show on `trip_o`: a sample whose operate/restraint point sits between the two slopes would trip or hold off at the wrong time. A stale window counter or a stale recorded sign shows as a disturbance that is classified, or left unclassified, one or more samples away from the sign change that should open the window. A miscounted pickup run or ride-out shows as `trip_o` or `secure_o` changing exactly one sample early or late.

// File: rtl/busdiff_pkg.sv
package busdiff_pkg;

    typedef enum logic [1:0] {
        CLS_NORMAL   = 2'd0,
        CLS_INTERNAL = 2'd1,
        CLS_EXTERNAL = 2'd2,
        CLS_HOLD     = 2'd3
    } cls_state_t;

    typedef enum logic [1:0] {
        TRP_IDLE    = 2'd0,
        TRP_TIMING  = 2'd1,
        TRP_TRIPPED = 2'd2
    } trp_state_t;

endpackage

// File: rtl/busdiff_norm.sv
module busdiff_norm #(
    parameter int SMP_W    = 8,
    parameter int TAP_W    = 6,
    parameter int TAP_FRAC = 4,
    parameter int NW       = SMP_W + TAP_W + 1
) (
    input  logic signed [SMP_W-1:0] smp,
    input  logic        [TAP_W-1:0] tap,
    input  logic                    pol,
    output logic signed [NW-1:0]    norm,
    output logic        [NW-1:0]    mag
);
    logic signed [NW-1:0] prod;
    logic signed [NW-1:0] scaled;

    // Tap is unsigned; widen with a zero sign bit before the signed multiply.
    assign prod   = NW'(smp) * NW'(signed'({1'b0, tap}));
    assign scaled = prod >>> TAP_FRAC;
    assign norm   = pol ? -scaled : scaled;
    assign mag    = norm[NW-1] ? NW'(-norm) : NW'(norm);

endmodule

// File: rtl/busdiff_sum.sv
module busdiff_sum #(
    parameter int N_CH = 4,
    parameter int NW   = 15,
    parameter int SW   = 17
) (
    input  logic [N_CH*NW-1:0] norm_flat,
    input  logic [N_CH*NW-1:0] mag_flat,
    output logic [SW-1:0]      op,
    output logic [SW-1:0]      rt,
    output logic               dom_neg
);
    logic signed [SW-1:0] acc;
    logic        [SW-1:0] racc;
    logic        [NW-1:0] best;
    logic                 bneg;

    always_comb begin
        acc  = '0;
        racc = '0;
        best = '0;
        bneg = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            acc  = acc + SW'($signed(norm_flat[i*NW +: NW]));
            racc = racc + SW'(mag_flat[i*NW +: NW]);
            // strict compare: lowest index wins ties
            if (mag_flat[i*NW +: NW] > best) begin
                best = mag_flat[i*NW +: NW];
                bneg = norm_flat[i*NW + NW - 1];
            end
        end
    end

    assign op      = acc[SW-1] ? SW'(-acc) : SW'(acc);
    assign rt      = racc;
    assign dom_neg = bneg;

endmodule

// File: rtl/busdiff_classify.sv
module busdiff_classify
    import busdiff_pkg::*;
#(
    parameter int SW    = 17,
    parameter int SLP_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_tick,
    input  logic [SW-1:0]    op,
    input  logic [SW-1:0]    rt,
    input  logic             dom_neg,
    input  logic [CNT_W-1:0] win_len,
    input  logic [SW-1:0]    rise_min,
    input  logic [SLP_W-1:0] prop,
    input  logic [SW-1:0]    rst_lvl,
    input  logic [CNT_W-1:0] hold_len,
    output logic             use_slope2,
    output logic             secure_q,
    output logic             internal_q
);
    localparam int DW = SW + 1;
    localparam int PW = SW + SLP_W + 2;

    cls_state_t st, st_nxt;
    logic [SW-1:0]    op_prev, rt_prev;
    logic             sgn_prev;
    logic [CNT_W-1:0] win_left;
    logic [CNT_W-1:0] hold_cnt, hold_nxt;

    logic signed [DW-1:0] d_rt, d_op;
    logic signed [PW-1:0] d_op_w, d_rt_w, lhs, rhs;
    logic chg, in_win, rt_rise, weak_op, ext_cond, int_cond, below;

    assign d_rt    = $signed({1'b0, rt}) - $signed({1'b0, rt_prev});
    assign d_op    = $signed({1'b0, op}) - $signed({1'b0, op_prev});
    assign d_op_w  = PW'(d_op);
    assign d_rt_w  = PW'(d_rt);
    assign lhs     = d_op_w <<< SLP_W;
    assign rhs     = d_rt_w * PW'(signed'({1'b0, prop}));
    assign chg     = (rt != '0) && (dom_neg != sgn_prev);
    assign in_win  = (chg && (win_len != '0)) || (win_left != '0);
    assign rt_rise = d_rt > $signed({1'b0, rise_min});
    assign weak_op = lhs < rhs;
    assign ext_cond = in_win && rt_rise && weak_op;
    assign int_cond = in_win && rt_rise && !weak_op;
    assign below   = rt < rst_lvl;

    always_comb begin
        st_nxt   = st;
        hold_nxt = hold_cnt;
        if (smp_tick) begin
            unique case (st)
                CLS_NORMAL: begin
                    if (ext_cond)      st_nxt = CLS_EXTERNAL;
                    else if (int_cond) st_nxt = CLS_INTERNAL;
                end
                CLS_INTERNAL: begin
                    if (below) st_nxt = CLS_NORMAL;
                end
                CLS_EXTERNAL: begin
                    if (below) begin
                        st_nxt   = CLS_HOLD;
                        hold_nxt = hold_len;
                    end
                end
                CLS_HOLD: begin
                    if (!below)                  st_nxt = CLS_EXTERNAL;
                    else if (hold_cnt <= CNT_W'(1)) st_nxt = CLS_NORMAL;
                    else                         hold_nxt = hold_cnt - 1'b1;
                end
                default: st_nxt = CLS_NORMAL;
            endcase
        end
    end

    assign use_slope2 = (st_nxt == CLS_EXTERNAL) || (st_nxt == CLS_HOLD);

    // state register and sample history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= CLS_NORMAL;
            hold_cnt <= '0;
            op_prev  <= '0;
            rt_prev  <= '0;
            sgn_prev <= 1'b0;
            win_left <= '0;
        end else begin
            st       <= st_nxt;
            hold_cnt <= hold_nxt;
            if (smp_tick) begin
                op_prev <= op;
                rt_prev <= rt;
                if (rt != '0) sgn_prev <= dom_neg;
                if (chg && (win_len != '0)) win_left <= win_len - 1'b1;
                else if (win_left != '0)    win_left <= win_left - 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secure_q   <= 1'b0;
            internal_q <= 1'b0;
        end else begin
            secure_q   <= use_slope2;
            internal_q <= (st_nxt == CLS_INTERNAL);
        end
    end

    // R3
    op_le_rt_chk: assert property (@(posedge clk) disable iff (!rst_n) op <= rt);
    // R6
    internal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        internal_q |=> !secure_q);
    // R8
    secure_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(secure_q));

endmodule

// File: rtl/busdiff_trip.sv
module busdiff_trip
    import busdiff_pkg::*;
#(
    parameter int SW    = 17,
    parameter int SLP_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_tick,
    input  logic             trip_rst,
    input  logic [SW-1:0]    op,
    input  logic [SW-1:0]    rt,
    input  logic             use_slope2,
    input  logic [SLP_W-1:0] slope1,
    input  logic [SLP_W-1:0] slope2,
    input  logic [SW-1:0]    min_op,
    input  logic [CNT_W-1:0] dly,
    input  logic             gap_en,
    input  logic [CNT_W-1:0] gap_extra,
    output logic             trip_q
);
    localparam int CW = SW + SLP_W + 1;
    localparam int TW = CNT_W + 1;

    trp_state_t st, st_nxt;
    logic [TW-1:0] pu_cnt, cnt_nxt, total;
    logic [CW-1:0] lhs, rhs;
    logic [SLP_W-1:0] slope;
    logic pickup;

    assign slope  = use_slope2 ? slope2 : slope1;
    assign lhs    = CW'(op) << SLP_W;
    assign rhs    = CW'(slope) * CW'(rt);
    assign pickup = (op > min_op) && (lhs > rhs);
    assign total  = TW'(dly) + (gap_en ? TW'(gap_extra) : TW'(0));

    always_comb begin
        st_nxt  = st;
        cnt_nxt = pu_cnt;
        if (trip_rst) begin
            st_nxt  = TRP_IDLE;
            cnt_nxt = '0;
        end else if (smp_tick) begin
            unique case (st)
                TRP_IDLE, TRP_TIMING: begin
                    if (!pickup) begin
                        st_nxt  = TRP_IDLE;
                        cnt_nxt = '0;
                    end else if (pu_cnt >= total) begin
                        st_nxt = TRP_TRIPPED;
                    end else begin
                        st_nxt  = TRP_TIMING;
                        cnt_nxt = pu_cnt + 1'b1;
                    end
                end
                TRP_TRIPPED: ;
                default: st_nxt = TRP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= TRP_IDLE;
            pu_cnt <= '0;
        end else begin
            st     <= st_nxt;
            pu_cnt <= cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trip_q <= 1'b0;
        else        trip_q <= (st_nxt == TRP_TRIPPED);
    end

    // R10
    trip_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_q && !trip_rst |=> trip_q);
    // R9
    trip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_q && !smp_tick |=> !trip_q);

endmodule

// File: rtl/busdiff_slope_elem.sv
module busdiff_slope_elem #(
    parameter int N_CH     = 4,
    parameter int SMP_W    = 8,
    parameter int TAP_W    = 6,
    parameter int TAP_FRAC = 4,
    parameter int SLP_W    = 8,
    parameter int LVL_W    = 16,
    parameter int CNT_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_tick,
    input  logic [N_CH*SMP_W-1:0]   smp_i,
    input  logic [N_CH*TAP_W-1:0]   tap_i,
    input  logic [N_CH-1:0]         pol_i,
    input  logic [SLP_W-1:0]        slope1_i,
    input  logic [SLP_W-1:0]        slope2_i,
    input  logic [LVL_W-1:0]        min_op_i,
    input  logic [SLP_W-1:0]        prop_i,
    input  logic [LVL_W-1:0]        rise_min_i,
    input  logic [CNT_W-1:0]        win_len_i,
    input  logic [LVL_W-1:0]        rst_lvl_i,
    input  logic [CNT_W-1:0]        hold_len_i,
    input  logic [CNT_W-1:0]        dly_i,
    input  logic                    gap_en_i,
    input  logic [CNT_W-1:0]        gap_extra_i,
    input  logic                    trip_rst_i,
    output logic                    trip_o,
    output logic                    secure_o,
    output logic                    internal_o
);
    localparam int NW = SMP_W + TAP_W + 1;
    localparam int SW = NW + $clog2(N_CH);

    logic [N_CH*NW-1:0] norm_flat, mag_flat;
    logic [SW-1:0] op, rt;
    logic dom_neg, use_slope2;

    for (genvar k = 0; k < N_CH; k++) begin : g_lane
        busdiff_norm #(
            .SMP_W(SMP_W), .TAP_W(TAP_W), .TAP_FRAC(TAP_FRAC), .NW(NW)
        ) i_norm (
            .smp  ($signed(smp_i[k*SMP_W +: SMP_W])),
            .tap  (tap_i[k*TAP_W +: TAP_W]),
            .pol  (pol_i[k]),
            .norm (norm_flat[k*NW +: NW]),
            .mag  (mag_flat[k*NW +: NW])
        );
    end

    busdiff_sum #(.N_CH(N_CH), .NW(NW), .SW(SW)) i_sum (
        .norm_flat (norm_flat),
        .mag_flat  (mag_flat),
        .op        (op),
        .rt        (rt),
        .dom_neg   (dom_neg)
    );

    busdiff_classify #(.SW(SW), .SLP_W(SLP_W), .CNT_W(CNT_W)) i_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_tick   (smp_tick),
        .op         (op),
        .rt         (rt),
        .dom_neg    (dom_neg),
        .win_len    (win_len_i),
        .rise_min   (SW'(rise_min_i)),
        .prop       (prop_i),
        .rst_lvl    (SW'(rst_lvl_i)),
        .hold_len   (hold_len_i),
        .use_slope2 (use_slope2),
        .secure_q   (secure_o),
        .internal_q (internal_o)
    );

    busdiff_trip #(.SW(SW), .SLP_W(SLP_W), .CNT_W(CNT_W)) i_trip (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_tick   (smp_tick),
        .trip_rst   (trip_rst_i),
        .op         (op),
        .rt         (rt),
        .use_slope2 (use_slope2),
        .slope1     (slope1_i),
        .slope2     (slope2_i),
        .min_op     (SW'(min_op_i)),
        .dly        (dly_i),
        .gap_en     (gap_en_i),
        .gap_extra  (gap_extra_i),
        .trip_q     (trip_o)
    );

endmodule

// File: tb/test_busdiff_slope_elem.sv
module test_busdiff_slope_elem;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_tick = 1'b0;
    logic [31:0] smp_i = '0;
    logic [23:0] tap_i = {6'd16, 6'd16, 6'd16, 6'd16};
    logic [3:0]  pol_i = '0;
    logic [7:0]  slope1_i = 8'd64, slope2_i = 8'd230, prop_i = 8'd128;
    logic [15:0] min_op_i = 16'd4, rise_min_i = 16'd2, rst_lvl_i = 16'd8;
    logic [7:0]  win_len_i = 8'd0, hold_len_i = 8'd2, dly_i = 8'd0, gap_extra_i = 8'd0;
    logic gap_en_i = 1'b0, trip_rst_i = 1'b0;
    logic trip_o, secure_o, internal_o;

    int checks = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    busdiff_slope_elem i_busdiff_slope_elem (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .smp_i(smp_i),
        .tap_i(tap_i), .pol_i(pol_i), .slope1_i(slope1_i), .slope2_i(slope2_i),
        .min_op_i(min_op_i), .prop_i(prop_i), .rise_min_i(rise_min_i),
        .win_len_i(win_len_i), .rst_lvl_i(rst_lvl_i), .hold_len_i(hold_len_i),
        .dly_i(dly_i), .gap_en_i(gap_en_i), .gap_extra_i(gap_extra_i),
        .trip_rst_i(trip_rst_i), .trip_o(trip_o), .secure_o(secure_o),
        .internal_o(internal_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic sample(input int a0, input int a1, input int a2, input int a3);
        @(negedge clk);
        smp_i = {8'(a3), 8'(a2), 8'(a1), 8'(a0)};
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
    endtask

    task automatic clear_trip();
        @(negedge clk);
        trip_rst_i = 1'b1;
        @(negedge clk);
        trip_rst_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    initial begin
        #(CLK_P * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset trip", trip_o, 1'b0);
        chk("R10 reset secure", secure_o, 1'b0);
        chk("R10 reset internal", internal_o, 1'b0);

        // R1 R2 R3 R4 sweep: ch0 tap 1.0, ch1 tap 2.0, polarity of ch1 swept
        tap_i = {6'd16, 6'd16, 6'd32, 6'd16};
        for (int p = 0; p < 2; p++) begin
            pol_i = 4'(p << 1);
            for (int a = -8; a < 8; a++) begin
                for (int b = -8; b < 8; b++) begin
                    int n0, n1, op, rt;
                    logic exp;
                    n0 = a * 5;
                    n1 = (p == 1) ? -(2 * b * 5) : 2 * b * 5;
                    op = iabs(n0 + n1);
                    rt = iabs(n0) + iabs(n1);
                    exp = (op > 4) && (op * 256 > 64 * rt);
                    clear_trip();
                    sample(a * 5, b * 5, 0, 0);
                    chk($sformatf("R4 R2 sweep a=%0d b=%0d pol=%0d", a, b, p), trip_o, exp);
                end
            end
        end
        pol_i = '0;

        // R1 floor rounding with tap 1.5 on ch2
        tap_i = {6'd16, 6'd24, 6'd16, 6'd16};
        clear_trip(); sample(0, 0, -3, 0); chk("R1 -3*1.5 floors to -5", trip_o, 1'b1);
        clear_trip(); sample(0, 0, 3, 0);  chk("R1 3*1.5 gives 4", trip_o, 1'b0);
        clear_trip(); sample(0, 0, -2, 0); chk("R1 -2*1.5 gives -3", trip_o, 1'b0);
        tap_i = {6'd16, 6'd16, 6'd16, 6'd16};

        // classifier
        win_len_i = 8'd3;
        do_reset();
        sample(-20, 20, 0, 0);
        chk("R5 external onset secure", secure_o, 1'b1);
        chk("R5 external onset not internal", internal_o, 1'b0);
        sample(-40, 10, 0, 0);
        chk("R5 slope2 blocks trip", trip_o, 1'b0);
        sample(0, 0, 0, 0);
        chk("R8 hold 1", secure_o, 1'b1);
        sample(0, 0, 0, 0);
        chk("R8 hold 2", secure_o, 1'b1);
        sample(0, 0, 0, 0);
        chk("R8 revert", secure_o, 1'b0);
        sample(20, 20, 0, 0);
        chk("R6 internal flag", internal_o, 1'b1);
        chk("R6 internal slope1", secure_o, 1'b0);
        chk("R6 internal trip", trip_o, 1'b1);
        sample(40, -10, 0, 0);
        chk("R6 external pattern ignored", secure_o, 1'b0);
        chk("R6 internal kept", internal_o, 1'b1);
        clear_trip();
        chk("R10 clear", trip_o, 1'b0);
        sample(0, 0, 0, 0);
        chk("R6 internal ends", internal_o, 1'b0);
        sample(-20, 20, 0, 0);
        chk("R5 second external", secure_o, 1'b1);
        sample(0, 0, 0, 0);
        chk("R8 enter hold", secure_o, 1'b1);
        sample(-10, 10, 0, 0);
        chk("R8 back to external", secure_o, 1'b1);
        sample(0, 0, 0, 0);
        sample(0, 0, 0, 0);
        chk("R8 hold count reloaded", secure_o, 1'b1);
        sample(0, 0, 0, 0);
        chk("R8 revert after reload", secure_o, 1'b0);
        sample(-20, 20, 0, 0);
        chk("R7 no sign change no window", secure_o, 1'b0);
        chk("R7 no sign change not internal", internal_o, 1'b0);

        // trip delay
        win_len_i = 8'd0;
        dly_i = 8'd3;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            sample(30, 0, 0, 0);
            chk($sformatf("R9 delay pickup %0d", i), trip_o, 1'b0);
        end
        sample(30, 0, 0, 0);
        chk("R9 trip after 4 pickups", trip_o, 1'b1);
        clear_trip();
        sample(30, 0, 0, 0); sample(30, 0, 0, 0); sample(0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            sample(30, 0, 0, 0);
            chk($sformatf("R9 restart %0d", i), trip_o, 1'b0);
        end
        sample(30, 0, 0, 0);
        chk("R9 trip after restart", trip_o, 1'b1);
        clear_trip();
        gap_en_i = 1'b1;
        gap_extra_i = 8'd2;
        for (int i = 0; i < 5; i++) begin
            sample(30, 0, 0, 0);
            chk($sformatf("R9 gap delay %0d", i), trip_o, 1'b0);
        end
        sample(30, 0, 0, 0);
        chk("R9 trip with gap delay", trip_o, 1'b1);
        sample(0, 0, 0, 0);
        sample(0, 0, 0, 0);
        chk("R10 latched", trip_o, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule